// File: doc/BRIEF.md
# Flash Write-Status Readback Generator

This block forms the word a host receives when it reads a flash device while an internal program or erase is running. A controller supplies the current operation mode, the bank that holds the operation, the sector that an erase was suspended on, and the data word being programmed. The array supplies the stored word. For each read, the block returns either that stored word or a status word. In a status word, bit 7 is a polling bit, and bits 6 and 2 are toggle bits that flip between consecutive reads.

A read counts as one read event when the output enable rises while the device is selected, and the address lies in the bank of the active operation. Read events advance the toggle bits. Bit 2 flips only for erase activity, so the host can tell an actively erasing sector from a suspended one. The block also drives a busy indicator as an active-low drive enable plus a drive value. Several devices can then share one wired, pulled-up ready line.

Top module: `wsb_status_gen`

## Requirements
- R1: With `op_mode` idle (code 0), `rd_data` equals `array_data` and `rb_en_n` is 1.
- R2: In program mode (code 1) or program-during-suspend mode (code 4), a read inside the operation's bank returns the inverse of `prog_data` bit 7 on bit 7, toggle bit A on bit 6 and toggle bit B on bit 2. All other bits carry `array_data`.
- R3: In erase mode (code 2), a read inside the operation's bank returns 0 on bit 7, toggle bit A on bit 6 and toggle bit B on bit 2.
- R4: In modes 1, 2 and 4, bit 6 of consecutive in-bank read events alternates, starting at 0.
- R5: In erase mode, bit 2 alternates on consecutive in-bank read events, starting at 0. In modes 1 and 4 it holds its value.
- R6: In erase-suspended mode (code 3), a read whose sector field (`rd_addr[20:11]`) equals `susp_sector` returns 1 on bit 7 and 1 on bit 6, and bit 2 alternates on consecutive such reads.
- R7: In erase-suspended mode, an in-bank read of any other sector returns `array_data`.
- R8: An address outside the operation's bank returns `array_data`, and the read does not advance the toggles. Bank 1 is `rd_addr >= 0x80000`; otherwise the address is in bank 0, selected by `op_bank`.
- R9: `rb_en_n` is 0 in modes 1, 2 and 4 and 1 in modes 0 and 3; `rb_val` is always 0.
- R10: A read event is a rising `oe_n` sampled on `clk` while `sel_n` was low. Toggles change only on read events or on an operation start.
- R11: When `op_mode` enters mode 1, 2 or 4 from a different mode, both toggles clear to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 3 | Operation mode code |
| op_bank | input | 1 | Bank holding the active operation |
| susp_sector | input | 10 | Sector index under erase suspend |
| rd_addr | input | 21 | Read address |
| sel_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output enable |
| prog_data | input | 16 | Word being programmed |
| array_data | input | 16 | Stored array word at `rd_addr` |
| rd_data | output | 16 | Word returned to the host |
| rb_en_n | output | 1 | Active-low drive enable for the ready line |
| rb_val | output | 1 | Value driven onto the ready line when enabled |

## Verification
The assertions check the following on every cycle:
- the word selection for each mode and bank, covering pass-through, the polling bit and the fixed bits for a suspended sector;
- the busy drive;
- that the toggles clear on an operation start, flip on in-bank read events and stay still otherwise.

Only the bench scenarios show the longer behaviour:
- the full alternating sequences across several read strobes;
- that strobes while deselected or to the other bank leave the next status read unchanged;
- the carry-over of bit 2 from an active erase into a suspend.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    typedef enum logic [2:0] {
        WSB_IDLE      = 3'd0,
        WSB_PROG      = 3'd1,
        WSB_ERASE     = 3'd2,
        WSB_SUSP      = 3'd3,
        WSB_SUSP_PROG = 3'd4
    } wsb_mode_e;

    typedef struct packed {
        logic oe_n;
        logic sel_n;
    } wsb_strobe_t;

    typedef struct packed {
        logic       tog_a;
        logic       tog_b;
        logic [2:0] mode;
    } wsb_tog_t;

    function automatic logic wsb_is_busy(input logic [2:0] m);
        return (m == WSB_PROG) || (m == WSB_ERASE) || (m == WSB_SUSP_PROG);
    endfunction

    function automatic logic wsb_is_prog(input logic [2:0] m);
        return (m == WSB_PROG) || (m == WSB_SUSP_PROG);
    endfunction

endpackage

// File: rtl/wsb_read_detect.sv
module wsb_read_detect
    import wsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic oe_n,
    output logic rd_evt
);

    wsb_strobe_t str_d, str_q;

    always_comb begin
        str_d       = str_q;
        str_d.oe_n  = oe_n;
        str_d.sel_n = sel_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            str_q <= '{oe_n: 1'b1, sel_n: 1'b1};
        end else begin
            str_q <= str_d;
        end
    end

    // Output enable released after a selected low phase
    assign rd_evt = !str_q.oe_n && oe_n && !str_q.sel_n;

endmodule

// File: rtl/wsb_addr_decode.sv
module wsb_addr_decode #(
    parameter int          ADDR_W     = 21,
    parameter int          SECT_LSB   = 11,
    parameter logic [20:0] BANK_BOUND = 21'h080000,
    localparam int         SECT_W     = ADDR_W - SECT_LSB
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              op_bank,
    input  logic [SECT_W-1:0] susp_sector,
    output logic              in_op_bank,
    output logic              in_susp_sect
);

    logic addr_bank;

    always_comb begin
        addr_bank    = (rd_addr >= ADDR_W'(BANK_BOUND));
        in_op_bank   = (addr_bank == op_bank);
        in_susp_sect = (rd_addr[ADDR_W-1:SECT_LSB] == susp_sector);
    end

endmodule

// File: rtl/wsb_toggle_unit.sv
module wsb_toggle_unit
    import wsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_mode,
    input  logic       rd_evt,
    input  logic       in_op_bank,
    input  logic       in_susp_sect,
    output logic       tog_a,
    output logic       tog_b,
    output logic       op_start
);

    wsb_tog_t tg_d, tg_q;

    always_comb begin
        tg_d      = tg_q;
        tg_d.mode = op_mode;
        op_start  = wsb_is_busy(op_mode) && (op_mode != tg_q.mode);
        if (op_start) begin
            tg_d.tog_a = 1'b0;
            tg_d.tog_b = 1'b0;
        end else if (rd_evt && in_op_bank) begin
            unique case (op_mode)
                WSB_PROG, WSB_SUSP_PROG: begin
                    tg_d.tog_a = ~tg_q.tog_a;
                end
                WSB_ERASE: begin
                    tg_d.tog_a = ~tg_q.tog_a;
                    tg_d.tog_b = ~tg_q.tog_b;
                end
                WSB_SUSP: begin
                    if (in_susp_sect) begin
                        tg_d.tog_b = ~tg_q.tog_b;
                    end
                end
                default: begin
                    tg_d.tog_a = tg_q.tog_a;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '{tog_a: 1'b0, tog_b: 1'b0, mode: WSB_IDLE};
        end else begin
            tg_q <= tg_d;
        end
    end

    assign tog_a = tg_q.tog_a;
    assign tog_b = tg_q.tog_b;

endmodule

// File: rtl/wsb_status_mux.sv
module wsb_status_mux
    import wsb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op_mode,
    input  logic              in_op_bank,
    input  logic              in_susp_sect,
    input  logic              tog_a,
    input  logic              tog_b,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rb_en_n,
    output logic              rb_val
);

    logic status_hit;
    logic poll_bit;
    logic bit6_val;

    always_comb begin
        status_hit = in_op_bank &&
                     (wsb_is_busy(op_mode) || ((op_mode == WSB_SUSP) && in_susp_sect));
        if (wsb_is_prog(op_mode)) begin
            poll_bit = ~prog_data[7];
        end else if (op_mode == WSB_SUSP) begin
            poll_bit = 1'b1;
        end else begin
            poll_bit = 1'b0;
        end
        bit6_val = (op_mode == WSB_SUSP) ? 1'b1 : tog_a;
        rb_en_n  = ~wsb_is_busy(op_mode);
        rb_val   = 1'b0;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == 7) begin : g_poll
            assign rd_data[i] = status_hit ? poll_bit : array_data[i];
        end else if (i == 6) begin : g_tog_a
            assign rd_data[i] = status_hit ? bit6_val : array_data[i];
        end else if (i == 2) begin : g_tog_b
            assign rd_data[i] = status_hit ? tog_b : array_data[i];
        end else begin : g_pass
            assign rd_data[i] = array_data[i];
        end
    end

endmodule

// File: rtl/wsb_status_gen.sv
module wsb_status_gen
    import wsb_pkg::*;
#(
    parameter int          ADDR_W     = 21,
    parameter int          DATA_W     = 16,
    parameter int          SECT_LSB   = 11,
    parameter logic [20:0] BANK_BOUND = 21'h080000,
    localparam int         SECT_W     = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode,
    input  logic              op_bank,
    input  logic [SECT_W-1:0] susp_sector,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rb_en_n,
    output logic              rb_val
);

    logic rd_evt;
    logic in_op_bank;
    logic in_susp_sect;
    logic tog_a;
    logic tog_b;
    logic op_start;

    wsb_read_detect u_rdet (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .oe_n   (oe_n),
        .rd_evt (rd_evt)
    );

    wsb_addr_decode #(
        .ADDR_W     (ADDR_W),
        .SECT_LSB   (SECT_LSB),
        .BANK_BOUND (BANK_BOUND)
    ) u_adec (
        .rd_addr      (rd_addr),
        .op_bank      (op_bank),
        .susp_sector  (susp_sector),
        .in_op_bank   (in_op_bank),
        .in_susp_sect (in_susp_sect)
    );

    wsb_toggle_unit u_tog (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_mode      (op_mode),
        .rd_evt       (rd_evt),
        .in_op_bank   (in_op_bank),
        .in_susp_sect (in_susp_sect),
        .tog_a        (tog_a),
        .tog_b        (tog_b),
        .op_start     (op_start)
    );

    wsb_status_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .op_mode      (op_mode),
        .in_op_bank   (in_op_bank),
        .in_susp_sect (in_susp_sect),
        .tog_a        (tog_a),
        .tog_b        (tog_b),
        .prog_data    (prog_data),
        .array_data   (array_data),
        .rd_data      (rd_data),
        .rb_en_n      (rb_en_n),
        .rb_val       (rb_val)
    );

endmodule

// File: rtl/wsb_status_chk.sv
module wsb_status_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_mode,
    input logic [DATA_W-1:0] prog_data,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rb_en_n,
    input logic              rb_val,
    input logic              rd_evt,
    input logic              op_start,
    input logic              in_op_bank,
    input logic              in_susp_sect,
    input logic              tog_a,
    input logic              tog_b
);

    logic busy_m;
    logic prog_m;
    assign busy_m = (op_mode == 3'd1) || (op_mode == 3'd2) || (op_mode == 3'd4);
    assign prog_m = (op_mode == 3'd1) || (op_mode == 3'd4);

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd0) |-> (rd_data == array_data && rb_en_n)); // R1
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_m && in_op_bank) |-> (rd_data[7] == ~prog_data[7] && rd_data[6] == tog_a)); // R2
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd2 && in_op_bank) |-> (rd_data[7] == 1'b0 && rd_data[2] == tog_b)); // R3
    AST_TOG_A_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && busy_m && in_op_bank && !op_start) |=> (tog_a != $past(tog_a))); // R4
    AST_TOG_B_HOLD_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_m && !op_start) |=> (tog_b == $past(tog_b))); // R5
    AST_SUSP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd3 && in_op_bank && in_susp_sect) |-> (rd_data[7:6] == 2'b11)); // R6
    AST_SUSP_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd3 && !in_susp_sect) |-> (rd_data == array_data)); // R7
    AST_FOREIGN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_op_bank) |-> (rd_data == array_data)); // R8
    AST_RB_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_en_n == !busy_m) && (rb_val == 1'b0)); // R9
    AST_TOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_evt && !op_start) |=> ($stable(tog_a) && $stable(tog_b))); // R10
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (!tog_a && !tog_b)); // R11

endmodule

bind wsb_status_gen wsb_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_mode      (op_mode),
    .prog_data    (prog_data),
    .array_data   (array_data),
    .rd_data      (rd_data),
    .rb_en_n      (rb_en_n),
    .rb_val       (rb_val),
    .rd_evt       (rd_evt),
    .op_start     (op_start),
    .in_op_bank   (in_op_bank),
    .in_susp_sect (in_susp_sect),
    .tog_a        (tog_a),
    .tog_b        (tog_b)
);

// File: tb/wsb_status_gen_tb.sv
module wsb_status_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_mode = 3'd0;
    logic        op_bank = 1'b0;
    logic [9:0]  susp_sector = 10'd0;
    logic [20:0] rd_addr = 21'h0;
    logic        sel_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] prog_data = 16'h0000;
    logic [15:0] array_data = 16'h5A3C;
    logic [15:0] rd_data;
    logic        rb_en_n;
    logic        rb_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wsb_status_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_mode     (op_mode),
        .op_bank     (op_bank),
        .susp_sector (susp_sector),
        .rd_addr     (rd_addr),
        .sel_n       (sel_n),
        .oe_n        (oe_n),
        .prog_data   (prog_data),
        .array_data  (array_data),
        .rd_data     (rd_data),
        .rb_en_n     (rb_en_n),
        .rb_val      (rb_val)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  mode;
        logic        bank;
        logic [20:0] addr;
        logic [9:0]  ssec;
        logic [15:0] exp;
        logic        rb;
    } vec_t;

    // array 0x5A3C, programmed word 0x0000, toggles at 0
    localparam vec_t VECS [10] = '{
        '{4'd1, 3'd0, 1'b0, 21'h001000, 10'd2, 16'h5A3C, 1'b1}, // R1
        '{4'd2, 3'd1, 1'b0, 21'h001000, 10'd2, 16'h5AB8, 1'b0}, // R2
        '{4'd3, 3'd2, 1'b0, 21'h001000, 10'd2, 16'h5A38, 1'b0}, // R3
        '{4'd8, 3'd2, 1'b1, 21'h001000, 10'd2, 16'h5A3C, 1'b0}, // R8
        '{4'd6, 3'd3, 1'b0, 21'h001000, 10'd2, 16'h5AF8, 1'b1}, // R6
        '{4'd7, 3'd3, 1'b0, 21'h001000, 10'd3, 16'h5A3C, 1'b1}, // R7
        '{4'd2, 3'd4, 1'b0, 21'h001000, 10'd2, 16'h5AB8, 1'b0}, // R2
        '{4'd8, 3'd1, 1'b1, 21'h100000, 10'd2, 16'h5AB8, 1'b0}, // R8
        '{4'd8, 3'd1, 1'b1, 21'h001000, 10'd2, 16'h5A3C, 1'b0}, // R8
        '{4'd9, 3'd0, 1'b1, 21'h100000, 10'd2, 16'h5A3C, 1'b1}  // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        op_mode = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    // one read strobe; returns the word seen while output enable is low
    task automatic do_read(input logic [20:0] a, input logic sel, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        sel_n = sel;
        oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        v = rd_data;
        oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        // reset state, R1
        check("R1", {15'd0, rd_data == array_data}, 32'd1);
        check("R9", {30'd0, rb_en_n, rb_val}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: each row from a fresh idle
        for (int k = 0; k < 10; k++) begin
            set_mode(3'd0);
            op_bank = VECS[k].bank;
            susp_sector = VECS[k].ssec;
            rd_addr = VECS[k].addr;
            set_mode(VECS[k].mode);
            sel_n = 1'b0;
            oe_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d data", VECS[k].req, k), {16'd0, rd_data}, {16'd0, VECS[k].exp});
            check($sformatf("R9 vec%0d rb", k), {30'd0, rb_en_n, rb_val}, {30'd0, VECS[k].rb, 1'b0});
            op_mode = 3'd0;
            @(negedge clk);
            oe_n = 1'b1;
            @(negedge clk);
            sel_n = 1'b1;
        end

        // R4 R5: erase, both toggles alternate from 0
        set_mode(3'd0);
        op_bank = 1'b0;
        susp_sector = 10'd2;
        set_mode(3'd2);
        for (int k = 0; k < 4; k++) begin
            do_read(21'h001000, 1'b0, v);
            check("R4 erase bit6", {31'd0, v[6]}, k % 2);
            check("R5 erase bit2", {31'd0, v[2]}, k % 2);
        end

        // R6: suspend on sector 2, bit2 continues alternating, bit7/bit6 fixed
        set_mode(3'd3);
        do_read(21'h001000, 1'b0, v);
        check("R6 susp bits", {29'd0, v[7], v[6], v[2]}, 32'b110);
        do_read(21'h001000, 1'b0, v);
        check("R6 susp bit2 flip", {31'd0, v[2]}, 32'd1);
        check("R9 susp ready", {31'd0, rb_en_n}, 32'd1);

        // R7: other sector while suspended
        do_read(21'h001800, 1'b0, v);
        check("R7 susp other sector", {16'd0, v}, 32'h5A3C);

        // R5 R11: program start clears; bit2 held across reads
        set_mode(3'd1);
        for (int k = 0; k < 3; k++) begin
            do_read(21'h001000, 1'b0, v);
            check("R11 R4 prog bit6", {31'd0, v[6]}, k % 2);
            check("R5 prog bit2 held", {31'd0, v[2]}, 32'd0);
        end

        // R10: strobes while deselected leave toggles alone (bit6 now 1)
        do_read(21'h001000, 1'b1, v);
        do_read(21'h001000, 1'b1, v);
        do_read(21'h001000, 1'b0, w);
        check("R10 deselected strobes", {31'd0, w[6]}, 32'd1);

        // R8: other-bank strobe returns array data and does not advance
        do_read(21'h100000, 1'b0, v);
        check("R8 other bank data", {16'd0, v}, 32'h5A3C);
        do_read(21'h001000, 1'b0, w);
        check("R8 no advance", {31'd0, w[6]}, 32'd0);

        // R11: direct change program -> erase is a start
        set_mode(3'd2);
        do_read(21'h001000, 1'b0, v);
        check("R11 restart bits", {30'd0, v[6], v[2]}, 32'd0);
        check("R3 erase poll", {31'd0, v[7]}, 32'd0);

        // R2: polling bit follows programmed data
        prog_data = 16'h0080;
        set_mode(3'd1);
        do_read(21'h001000, 1'b0, v);
        check("R2 poll inverse", {31'd0, v[7]}, 32'd0);
        check("R2 pass bits", {16'd0, v & 16'hFF3B}, {16'd0, 16'h5A3C & 16'hFF3B});

        // R1: back to idle gives array data
        set_mode(3'd0);
        do_read(21'h001000, 1'b0, v);
        check("R1 idle data", {16'd0, v}, 32'h5A3C);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule